// File: doc/BRIEF.md
# Serial Command Decoder for an SPI Burst Master

This block turns a stream of bytes, already recovered from a byte-oriented serial slave port, into actions for an SPI burst engine. Every transaction opens with an address phase that says whether it reads or writes. The block answers that phase with an accept or a refuse pulse. The first byte of a write is a function code that picks one of two actions. Code `0xF0` routes the next byte into an 8-bit configuration register. Codes `0x01`..`0x0F` are a mask of slave selects, and the bytes that follow are stored in a data buffer starting at position 0. When the stop strobe closes such a write, the block starts an SPI burst. The burst covers as many bytes as were stored, and it drives the chosen selects.

While a burst runs, the engine reads the buffer and writes the bytes it receives back into the same positions. A later read transaction streams the buffer to the host from position 0. Until the engine reports that the burst is done, every new transaction is refused at its address phase. The host therefore polls until it is accepted.

Top module: `cmd_front_end`

## Requirements
- R1: After reset `busy`, `burstStart`, `addrAck`, `addrNack`, `dataAck`, `dataNack` are 0 and `cfgReg` is 0x00.
- R2: An address phase (`addrValid`) seen while not busy gives a one-cycle `addrAck` on the next cycle. Seen while busy, it gives `addrNack` instead, and every byte, read request and stop of that refused transaction has no effect: bytes get `dataNack`, reads return 0xFF and no burst starts.
- R3: In a write, the function byte 0xF0 is acknowledged and the next byte is loaded into `cfgReg` and acknowledged. Any further bytes in that transaction are refused, and no burst starts at its stop.
- R4: A function byte whose upper nibble is 0 and whose low nibble is nonzero, with no bit set at position `NUM_SEL` or above, is acknowledged. The bytes after it are each acknowledged and stored at buffer positions 0, 1, 2, ... in order.
- R5: A stop that ends such a write with N ≥ 1 stored bytes gives a one-cycle `burstStart` on the next cycle, with `burstLen` = N and `burstSel` = the low nibble of the function byte. `busy` rises in the same cycle. The stored bytes are visible on `engRdAddr`/`engRdData`.
- R6: A data write that stops with zero stored bytes starts no burst.
- R7: Data bytes beyond the `DEPTH`-th are refused with `dataNack` and not stored, so the burst length never exceeds `DEPTH`.
- R8: A select mask with a bit set at position `NUM_SEL` or above is refused with `dataNack`, and the rest of that transaction is refused. No burst starts and the buffer is left unchanged.
- R9: Any other function byte (0x00, 0x10..0xEF, 0xF1..0xFF) is refused, and the buffer and `cfgReg` stay unchanged.
- R10: In an accepted read, each `rdReq` returns on the next cycle the buffer byte at positions 0, 1, 2, ... in turn. Past position `DEPTH-1` it returns 0xFF.
- R11: While `busy`, an engine write (`engWrEn`) stores `engWrData` at `engWrAddr`. A `burstDone` pulse clears `busy` on the next cycle, and no new burst can start while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Address phase of a new transaction |
| addrRead | input | 1 | 1 = read transaction, 0 = write (valid with addrValid) |
| wrValid | input | 1 | A write byte is present on wrByte |
| wrByte | input | 8 | Received write byte |
| rdReq | input | 1 | Host clocks out one read byte |
| stopStrobe | input | 1 | End of transaction |
| addrAck | output | 1 | Address phase accepted |
| addrNack | output | 1 | Address phase refused |
| dataAck | output | 1 | Write byte accepted |
| dataNack | output | 1 | Write byte refused |
| rdData | output | 8 | Read byte returned for the last rdReq |
| cfgReg | output | 8 | Configuration register |
| burstStart | output | 1 | One-cycle burst launch pulse |
| burstLen | output | $clog2(DEPTH+1) | Burst length in bytes |
| burstSel | output | 4 | Slave-select mask for the burst |
| busy | output | 1 | Burst in progress |
| burstDone | input | 1 | Engine finished the burst |
| engRdAddr | input | $clog2(DEPTH) | Engine buffer read address |
| engRdData | output | 8 | Buffer byte at engRdAddr (combinational) |
| engWrEn | input | 1 | Engine writes a received byte |
| engWrAddr | input | $clog2(DEPTH) | Engine write address |
| engWrData | input | 8 | Engine write byte |

## Verification
On every cycle the assertions check these properties: the address phase is refused exactly when a burst is running; a launch always carries a legal nonzero select mask and a length between 1 and `DEPTH`; no launch happens while busy; `busy` falls after `burstDone`; `cfgReg` changes only when a byte arrives; byte replies only follow write bytes. Some behaviour depends on what was written and in what order, and only the bench scenarios can show it. This covers the stored buffer contents and their readback order, the 0xFF past the end, the engine's write-back showing up in a later read, and the fact that ignored or refused transactions leave buffer and configuration untouched. The bench sweeps all 256 function codes and every fill length from 0 to past the buffer capacity.

// File: rtl/cmd_front_pkg.sv
package cmd_front_pkg;

  localparam logic [7:0] FUNC_CFG = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FUNC,
    ST_CFG,
    ST_DATA,
    ST_DROP,
    ST_READ
  } cmdState_t;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic clrCnt;
    logic storeByte;
    logic loadCfg;
    logic rdRestart;
    logic rdNext;
    logic rdBlank;
  } dpCtrl_t;

endpackage

// File: rtl/cmd_front_ctrl.sv
module cmd_front_ctrl
  import cmd_front_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrValid,
  input  logic             addrRead,
  input  logic             wrValid,
  input  logic [7:0]       wrByte,
  input  logic             rdReq,
  input  logic             stopStrobe,
  input  logic             burstDone,
  input  logic [CNT_W-1:0] fillCnt,
  input  logic             bufFull,
  output dpCtrl_t          strobes,
  output logic             addrAck,
  output logic             addrNack,
  output logic             dataAck,
  output logic             dataNack,
  output logic             burstStart,
  output logic [CNT_W-1:0] burstLen,
  output logic [3:0]       burstSel,
  output logic             busy
);

  localparam logic [3:0] SEL_OK = 4'((1 << NUM_SEL) - 1);

  cmdState_t state, nextState;
  logic [3:0] selLatch;
  logic ackAddrNext, nackAddrNext, ackDataNext, nackDataNext, launchNext;
  logic funcIsData;

  assign funcIsData = (wrByte[7:4] == 4'h0) && (wrByte[3:0] != 4'h0) &&
                      ((wrByte[3:0] & ~SEL_OK) == 4'h0);

  always_comb begin
    nextState    = state;
    strobes      = '0;
    ackAddrNext  = 1'b0;
    nackAddrNext = 1'b0;
    ackDataNext  = 1'b0;
    nackDataNext = 1'b0;
    launchNext   = 1'b0;
    if (addrValid) begin
      if (busy) begin
        nackAddrNext = 1'b1;
        nextState    = ST_IDLE;
      end else begin
        ackAddrNext = 1'b1;
        if (addrRead) begin
          nextState         = ST_READ;
          strobes.rdRestart = 1'b1;
        end else begin
          nextState = ST_FUNC;
        end
      end
    end else if (stopStrobe) begin
      if (state == ST_DATA && fillCnt != '0) launchNext = 1'b1;
      nextState = ST_IDLE;
    end else begin
      if (wrValid) begin
        case (state)
          ST_FUNC: begin
            if (wrByte == FUNC_CFG) begin
              ackDataNext = 1'b1;
              nextState   = ST_CFG;
            end else if (funcIsData) begin
              ackDataNext    = 1'b1;
              strobes.clrCnt = 1'b1;
              nextState      = ST_DATA;
            end else begin
              nackDataNext = 1'b1;
              nextState    = ST_DROP;
            end
          end
          ST_CFG: begin
            ackDataNext     = 1'b1;
            strobes.loadCfg = 1'b1;
            nextState       = ST_DROP;
          end
          ST_DATA: begin
            if (!bufFull) begin
              ackDataNext       = 1'b1;
              strobes.storeByte = 1'b1;
            end else begin
              nackDataNext = 1'b1;
            end
          end
          default: nackDataNext = 1'b1;
        endcase
      end
      if (rdReq) begin
        if (state == ST_READ) strobes.rdNext = 1'b1;
        else strobes.rdBlank = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      addrAck    <= 1'b0;
      addrNack   <= 1'b0;
      dataAck    <= 1'b0;
      dataNack   <= 1'b0;
      burstStart <= 1'b0;
      burstLen   <= '0;
      burstSel   <= 4'h0;
      selLatch   <= 4'h0;
    end else begin
      state      <= nextState;
      addrAck    <= ackAddrNext;
      addrNack   <= nackAddrNext;
      dataAck    <= ackDataNext;
      dataNack   <= nackDataNext;
      burstStart <= launchNext;
      if (strobes.clrCnt) selLatch <= wrByte[3:0];
      if (launchNext) begin
        busy     <= 1'b1;
        burstLen <= fillCnt;
        burstSel <= selLatch;
      end else if (burstDone) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmd_front_dp.sv
module cmd_front_dp
  import cmd_front_pkg::*;
#(
  parameter int DEPTH  = 200,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [7:0]        wrByte,
  input  logic [ADDR_W-1:0] engRdAddr,
  input  logic              engWrEn,
  input  logic [ADDR_W-1:0] engWrAddr,
  input  logic [7:0]        engWrData,
  output logic [7:0]        engRdData,
  output logic [CNT_W-1:0]  fillCnt,
  output logic              bufFull,
  output logic [7:0]        rdData,
  output logic [7:0]        cfgReg
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] rdPtr;

  assign bufFull   = (fillCnt == DEPTH_C);
  assign engRdData = (CNT_W'(engRdAddr) < DEPTH_C) ? mem[engRdAddr] : 8'hFF;

  // engine write-back has priority; host stores are refused while busy
  always_ff @(posedge clk) begin
    if (engWrEn && (CNT_W'(engWrAddr) < DEPTH_C))
      mem[engWrAddr] <= engWrData;
    else if (strobes.storeByte)
      mem[fillCnt[ADDR_W-1:0]] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      rdPtr   <= '0;
      rdData  <= 8'h00;
      cfgReg  <= 8'h00;
    end else begin
      if (strobes.clrCnt) fillCnt <= '0;
      else if (strobes.storeByte) fillCnt <= fillCnt + 1'b1;

      if (strobes.loadCfg) cfgReg <= wrByte;

      if (strobes.rdRestart) begin
        rdPtr <= '0;
      end else if (strobes.rdNext) begin
        if (rdPtr < DEPTH_C) begin
          rdData <= mem[rdPtr[ADDR_W-1:0]];
          rdPtr  <= rdPtr + 1'b1;
        end else begin
          rdData <= 8'hFF;
        end
      end else if (strobes.rdBlank) begin
        rdData <= 8'hFF;
      end
    end
  end

endmodule

// File: rtl/cmd_front_end.sv
module cmd_front_end
  import cmd_front_pkg::*;
#(
  parameter int DEPTH   = 200,
  parameter int NUM_SEL = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              addrRead,
  input  logic              wrValid,
  input  logic [7:0]        wrByte,
  input  logic              rdReq,
  input  logic              stopStrobe,
  output logic              addrAck,
  output logic              addrNack,
  output logic              dataAck,
  output logic              dataNack,
  output logic [7:0]        rdData,
  output logic [7:0]        cfgReg,
  output logic              burstStart,
  output logic [CNT_W-1:0]  burstLen,
  output logic [3:0]        burstSel,
  output logic              busy,
  input  logic              burstDone,
  input  logic [ADDR_W-1:0] engRdAddr,
  output logic [7:0]        engRdData,
  input  logic              engWrEn,
  input  logic [ADDR_W-1:0] engWrAddr,
  input  logic [7:0]        engWrData
);

  dpCtrl_t          strobes;
  logic [CNT_W-1:0] fillCnt;
  logic             bufFull;

  cmd_front_ctrl #(.NUM_SEL(NUM_SEL), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .addrValid(addrValid), .addrRead(addrRead),
    .wrValid(wrValid), .wrByte(wrByte),
    .rdReq(rdReq), .stopStrobe(stopStrobe), .burstDone(burstDone),
    .fillCnt(fillCnt), .bufFull(bufFull), .strobes(strobes),
    .addrAck(addrAck), .addrNack(addrNack),
    .dataAck(dataAck), .dataNack(dataNack),
    .burstStart(burstStart), .burstLen(burstLen), .burstSel(burstSel),
    .busy(busy)
  );

  cmd_front_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrByte(wrByte),
    .engRdAddr(engRdAddr), .engWrEn(engWrEn),
    .engWrAddr(engWrAddr), .engWrData(engWrData),
    .engRdData(engRdData), .fillCnt(fillCnt), .bufFull(bufFull),
    .rdData(rdData), .cfgReg(cfgReg)
  );

endmodule

// File: rtl/cmd_front_chk.sv
module cmd_front_chk #(
  parameter int DEPTH   = 200,
  parameter int NUM_SEL = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             addrValid,
  input logic             busy,
  input logic             addrAck,
  input logic             addrNack,
  input logic             wrValid,
  input logic             dataAck,
  input logic             dataNack,
  input logic [7:0]       cfgReg,
  input logic             burstStart,
  input logic [CNT_W-1:0] burstLen,
  input logic [3:0]       burstSel,
  input logic             burstDone
);

  localparam logic [3:0]       SEL_OK  = 4'((1 << NUM_SEL) - 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  assert_busy_refuse_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && busy |=> addrNack && !addrAck);

  assert_idle_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !busy |=> addrAck && !addrNack);

  assert_cfg_on_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgReg) |-> $past(wrValid));

  assert_reply_follows_byte_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataAck || dataNack) |-> $past(wrValid));

  assert_launch_sets_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> busy);

  assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> burstLen != '0);

  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> burstLen <= DEPTH_C);

  assert_sel_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> (burstSel != 4'h0) && ((burstSel & ~SEL_OK) == 4'h0));

  assert_no_launch_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> !$past(busy));

  assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy && burstDone |=> !busy);

endmodule

bind cmd_front_end cmd_front_chk #(.DEPTH(DEPTH), .NUM_SEL(NUM_SEL)) chk_i (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .busy(busy),
  .addrAck(addrAck), .addrNack(addrNack), .wrValid(wrValid),
  .dataAck(dataAck), .dataNack(dataNack), .cfgReg(cfgReg),
  .burstStart(burstStart), .burstLen(burstLen), .burstSel(burstSel),
  .burstDone(burstDone)
);

// File: tb/cmd_front_end_tb_top.sv
`timescale 1ns/1ps
module cmd_front_end_tb_top;

  localparam int DEPTH   = 8;
  localparam int NUM_SEL = 3;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ADDR_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrValid = 0, addrRead = 0, wrValid = 0, rdReq = 0, stopStrobe = 0;
  logic [7:0] wrByte = 8'h00;
  logic burstDone = 0, engWrEn = 0;
  logic [ADDR_W-1:0] engRdAddr = '0, engWrAddr = '0;
  logic [7:0] engWrData = 8'h00;
  logic addrAck, addrNack, dataAck, dataNack, burstStart, busy;
  logic [7:0] rdData, cfgReg, engRdData;
  logic [CNT_W-1:0] burstLen;
  logic [3:0] burstSel;

  int total = 0;
  int fails = 0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] mdlCfg = 8'h00;

  always #5 clk = ~clk;

  cmd_front_end #(.DEPTH(DEPTH), .NUM_SEL(NUM_SEL)) dut_i (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrRead(addrRead),
    .wrValid(wrValid), .wrByte(wrByte), .rdReq(rdReq), .stopStrobe(stopStrobe),
    .addrAck(addrAck), .addrNack(addrNack), .dataAck(dataAck), .dataNack(dataNack),
    .rdData(rdData), .cfgReg(cfgReg), .burstStart(burstStart), .burstLen(burstLen),
    .burstSel(burstSel), .busy(busy), .burstDone(burstDone),
    .engRdAddr(engRdAddr), .engRdData(engRdData), .engWrEn(engWrEn),
    .engWrAddr(engWrAddr), .engWrData(engWrData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic addrPhase(input bit rd, input bit expAck, input string tag);
    @(negedge clk); addrValid = 1; addrRead = rd;
    @(negedge clk); addrValid = 0; addrRead = 0;
    chk(tag, {addrAck, addrNack}, expAck ? 2 : 1);
  endtask

  task automatic wrB(input logic [7:0] b, input bit expAck, input string tag);
    @(negedge clk); wrValid = 1; wrByte = b;
    @(negedge clk); wrValid = 0;
    chk(tag, {dataAck, dataNack}, expAck ? 2 : 1);
  endtask

  task automatic stopT(input bit expL, input int len, input int sel, input string tag);
    @(negedge clk); stopStrobe = 1;
    @(negedge clk); stopStrobe = 0;
    chk(tag, burstStart, expL);
    if (expL) begin
      chk({tag, " len"}, burstLen, len);
      chk({tag, " sel"}, burstSel, sel);
      chk({tag, " busy"}, busy, 1);
    end
  endtask

  task automatic rdB(input int exp, input string tag);
    @(negedge clk); rdReq = 1;
    @(negedge clk); rdReq = 0;
    chk(tag, rdData, exp);
  endtask

  task automatic engWr(input int a, input logic [7:0] d);
    @(negedge clk); engWrEn = 1; engWrAddr = ADDR_W'(a); engWrData = d;
    @(negedge clk); engWrEn = 0;
  endtask

  task automatic finishBurst();
    @(negedge clk); burstDone = 1;
    @(negedge clk); burstDone = 0;
    chk("R11 busy cleared", busy, 0);
  endtask

  function automatic logic [7:0] hostVal(input int n, input int i);
    return 8'((n * 37 + i * 5 + 3) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 cfg", cfgReg, 0);
    chk("R1 launch", burstStart, 0);
    chk("R1 replies", {addrAck, addrNack, dataAck, dataNack}, 0);
    rstN = 1;

    // initial full fill to give the buffer known contents (R4, R5)
    addrPhase(0, 1, "R2 accept");
    wrB(8'h01, 1, "R4 func");
    for (int i = 0; i < DEPTH; i++) begin
      wrB(8'(i + 8'h40), 1, "R4 data");
      mdl[i] = 8'(i + 8'h40);
    end
    stopT(1, DEPTH, 1, "R5 launch");
    finishBurst();

    // sweep all function codes
    for (int c = 0; c < 256; c++) begin
      logic [7:0] code, b1, b2;
      bit isCfg, isData;
      code = 8'(c);
      b1 = code ^ 8'h5A;
      b2 = code + 8'h01;
      isCfg = (code == 8'hF0);
      isData = (code[7:4] == 4'h0) && (code[3:0] != 4'h0) && (code[3] == 1'b0);
      addrPhase(0, 1, "R2 accept");
      wrB(code, isCfg || isData, isData ? "R4 func" : (isCfg ? "R3 func" : "R9/R8 refuse"));
      wrB(b1, isCfg || isData, isCfg ? "R3 cfg byte" : "R9/R8 data");
      wrB(b2, isData, isCfg ? "R3 extra byte" : "R9/R8 data");
      if (isData) begin mdl[0] = b1; mdl[1] = b2; end
      if (isCfg) mdlCfg = b1;
      stopT(isData, 2, int'(code[3:0]), isData ? "R5 launch" : "R3/R8/R9 no launch");
      if (isData) begin
        addrPhase(1, 0, "R2 busy refuse");
        finishBurst();
      end
      chk("R3/R9 cfg", cfgReg, mdlCfg);
      addrPhase(1, 1, "R10 accept");
      rdB(mdl[0], "R10/R9 byte0");
      rdB(mdl[1], "R10/R9 byte1");
    end

    // sweep fill lengths through and past capacity
    for (int n = 0; n <= DEPTH + 2; n++) begin
      int len, sel;
      len = (n < DEPTH) ? n : DEPTH;
      sel = (n % 7) + 1;
      addrPhase(0, 1, "R2 accept");
      wrB(8'(sel), 1, "R4 func");
      for (int i = 0; i < n; i++) begin
        wrB(hostVal(n, i), i < DEPTH, i < DEPTH ? "R4 data" : "R7 overflow");
        if (i < DEPTH) mdl[i] = hostVal(n, i);
      end
      stopT(n > 0, len, sel, n > 0 ? "R5 launch" : "R6 empty");
      if (n > 0) begin
        for (int i = 0; i < len; i++) begin
          @(negedge clk); engRdAddr = ADDR_W'(i);
          #1 chk("R5 engine sees data", engRdData, mdl[i]);
        end
        if (n == 3) begin
          addrPhase(0, 0, "R2 busy refuse write");
          wrB(8'h02, 0, "R2 refused func");
          wrB(8'h77, 0, "R2 refused data");
          stopT(0, 0, 0, "R2 refused stop");
          addrPhase(1, 0, "R2 busy refuse read");
          rdB(8'hFF, "R2 refused read");
        end
        for (int i = 0; i < len; i++) begin
          engWr(i, hostVal(n, i) ^ 8'hC3);
          mdl[i] = hostVal(n, i) ^ 8'hC3;
        end
        finishBurst();
      end
      addrPhase(1, 1, "R10 accept");
      for (int i = 0; i < DEPTH + 2; i++)
        rdB(i < DEPTH ? int'(mdl[i]) : 8'hFF, i < DEPTH ? "R10/R11 readback" : "R10 past end");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule